// File: doc/BRIEF.md
# Erased Page Bit-Flip Checker

After the ECC decoder of a flash controller flags a page as uncorrectable, that page may simply be erased: all ones, with a few bits that read as zero. This block settles the question in hardware. It takes the ECC status byte, and if the decoder reported no failure it passes on the corrected-error count without scanning anything. If the decoder reported a failure, the block takes the page back as a stream of words, data area first and spare area second. It counts the zero bits in each word and adds them to one running total for the whole page.

The total is compared against half of the ECC strength. At or below that limit the page is declared erased, and the flip count is reported; the caller then treats the page contents as all 0xFF. Above the limit the page has failed. Once the running total crosses the limit, counting stops, but the rest of the stream is still consumed so that the source stays aligned to page boundaries. The verdict is registered and held until the next status byte is accepted.

Top module: `erased_page_checker`

## Requirements
- R1: When bit 7 of an accepted status byte is 0, the next cycle shows res_valid=1, res_fail=0, res_erased=0 and res_count equal to bits 5:0 of that byte. Bit 6 has no effect, and no words are taken.
- R2: When bit 7 of an accepted status byte is 1, a scan begins. From the next cycle stat_ready is 0, word_ready is 1 and res_valid is 0, and this holds until exactly DATA_BYTES/4 + SPARE_BYTES/4 words have been accepted.
- R3: During a scan, each accepted word adds its number of zero bits to one running total, one word per cycle. Spare-area words add to the same total as data-area words, and gaps in word_valid do not change the result.
- R4: The threshold is ECC_STRENGTH/2, using integer division.
- R5: Once the running total exceeds the threshold, later words add nothing, in either area, but they are still accepted.
- R6: One cycle after the last spare word is accepted, if the total is above the threshold, res_valid=1, res_fail=1, res_erased=0 and res_count equals the total at the point where counting stopped.
- R7: One cycle after the last spare word is accepted, if the total is at most the threshold, res_valid=1, res_erased=1, res_fail=0 and res_count equals the total.
- R8: A result stays unchanged until the next status byte is accepted. Accepting a status byte with bit 7 set drops res_valid.
- R9: After reset, stat_ready=1, word_ready=0, res_valid=0, res_fail=0, res_erased=0 and res_count=0.
- R10: Outside a scan, word_ready is 0. Words offered there are neither taken nor counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| stat_valid | input | 1 | ECC status byte offered |
| stat_ready | output | 1 | Block can take a status byte (idle) |
| stat_byte | input | 8 | ECC status: bit 7 uncorrectable, bits 5:0 corrected count |
| word_valid | input | 1 | Page word offered |
| word_ready | output | 1 | Block takes page words (scanning) |
| word_data | input | WORD_W | Page word, data area first, then spare area |
| res_valid | output | 1 | Result present and held |
| res_fail | output | 1 | Page failed: too many zero bits |
| res_erased | output | 1 | Page is erased with res_count flips |
| res_count | output | CNT_W | Corrected count or flip count |

## Verification
The bench builds the block with ECC_STRENGTH=8, which gives a threshold of 4, and with a 64-byte data area and a 16-byte spare area, so a page is 20 words. With these values a page can land exactly on the threshold, one bit above it, or far above it, using only a few patterned words. The threshold crossing can be placed in either area, and the early stop and drain show up in a short scan. A behavioural reference model predicts the handshake outputs and the result on every cycle, and directed scenarios add explicit expected values for each corner case.

// File: rtl/epc_pkg.sv
package epc_pkg;

  // Field positions in the ECC status byte
  localparam int STAT_FAIL_POS = 7;
  localparam int STAT_CNT_W    = 6;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DATA  = 2'd1,
    ST_SPARE = 2'd2
  } scan_state_e;

  typedef struct packed {
    logic                  uncorrectable;
    logic [STAT_CNT_W-1:0] corrected;
  } ecc_stat_t;

  function automatic ecc_stat_t decode_status(input logic [7:0] b);
    ecc_stat_t s;
    s.uncorrectable = b[STAT_FAIL_POS];
    s.corrected     = b[STAT_CNT_W-1:0];
    return s;
  endfunction

  // Erased-page limit: half the correction strength
  function automatic int flip_threshold(input int strength);
    return strength / 2;
  endfunction

  // Width that holds the corrected count and the worst frozen total
  function automatic int count_width(input int thresh, input int word_w);
    int need;
    need = $clog2(thresh + word_w + 1);
    return (need > STAT_CNT_W) ? need : STAT_CNT_W;
  endfunction

endpackage

// File: rtl/epc_zero_count.sv
module epc_zero_count #(
  parameter int WORD_W = 32,
  parameter int LANE_W = 8,
  parameter int ZW     = $clog2(WORD_W + 1)
) (
  input  logic [WORD_W-1:0] word,
  output logic [ZW-1:0]     zeros
);

  localparam int LANES = WORD_W / LANE_W;
  localparam int LW    = $clog2(LANE_W + 1);

  function automatic logic [LW-1:0] lane_zeros(input logic [LANE_W-1:0] v);
    logic [LW-1:0] c;
    c = '0;
    for (int b = 0; b < LANE_W; b++) begin
      c = c + (v[b] ? LW'(0) : LW'(1));
    end
    return c;
  endfunction

  logic [LANES-1:0][LW-1:0] lane_cnt;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_cnt[g] = lane_zeros(word[g*LANE_W +: LANE_W]);
  end

  always_comb begin
    zeros = '0;
    for (int l = 0; l < LANES; l++) begin
      zeros = zeros + ZW'(lane_cnt[l]);
    end
  end

endmodule

// File: rtl/epc_flip_accum.sv
module epc_flip_accum #(
  parameter int CNT_W  = 6,
  parameter int ZW     = 6,
  parameter int THRESH = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             add_en,
  input  logic [ZW-1:0]    zeros,
  output logic [CNT_W-1:0] total,
  output logic             stopped,
  output logic [CNT_W-1:0] total_next,
  output logic             over_next
);

  logic [CNT_W-1:0] sum_w;
  logic             take;

  assign take       = add_en && !stopped;
  assign sum_w      = total + CNT_W'(zeros);
  assign total_next = take ? sum_w : total;
  assign over_next  = total_next > CNT_W'(THRESH);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      total   <= '0;
      stopped <= 1'b0;
    end else if (take) begin
      total   <= sum_w;
      stopped <= sum_w > CNT_W'(THRESH);
    end
  end

  // R5
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stopped && !clear |=> $stable(total));

  // R5
  stop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (total > CNT_W'(THRESH)) |-> stopped);

endmodule

// File: rtl/epc_scan_ctrl.sv
module epc_scan_ctrl
  import epc_pkg::*;
#(
  parameter int DATA_WORDS  = 512,
  parameter int SPARE_WORDS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic word_valid,
  output logic status_ready,
  output logic word_ready,
  output logic word_fire,
  output logic last_word,
  output logic area_switch
);

  localparam int MAXW = (DATA_WORDS > SPARE_WORDS) ? DATA_WORDS : SPARE_WORDS;
  localparam int IW   = (MAXW > 1) ? $clog2(MAXW) : 1;

  scan_state_e   state_q, state_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          data_last, spare_last;

  assign status_ready = (state_q == ST_IDLE);
  assign word_ready   = (state_q != ST_IDLE);
  assign word_fire    = word_valid && word_ready;
  assign data_last    = (state_q == ST_DATA)  && (int'(idx_q) == DATA_WORDS - 1);
  assign spare_last   = (state_q == ST_SPARE) && (int'(idx_q) == SPARE_WORDS - 1);
  assign last_word    = word_fire && spare_last;
  assign area_switch  = word_fire && data_last;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_DATA;
        idx_d   = '0;
      end
      ST_DATA: if (word_fire) begin
        if (data_last) begin
          state_d = ST_SPARE;
          idx_d   = '0;
        end else begin
          idx_d = idx_q + IW'(1);
        end
      end
      ST_SPARE: if (word_fire) begin
        if (spare_last) begin
          state_d = ST_IDLE;
          idx_d   = '0;
        end else begin
          idx_d = idx_q + IW'(1);
        end
      end
      default: begin
        state_d = ST_IDLE;
        idx_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  // R2
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA) |-> (int'(idx_q) < DATA_WORDS));

  // R2
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_ready && !last_word |=> word_ready);

  // R10
  idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_ready && !start |=> status_ready && !word_ready);

endmodule

// File: rtl/erased_page_checker.sv
module erased_page_checker
  import epc_pkg::*;
#(
  parameter int ECC_STRENGTH = 24,
  parameter int DATA_BYTES   = 2048,
  parameter int SPARE_BYTES  = 64,
  parameter int WORD_W       = 32,
  localparam int THRESH      = flip_threshold(ECC_STRENGTH),
  localparam int CNT_W       = count_width(THRESH, WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_valid,
  output logic              stat_ready,
  input  logic [7:0]        stat_byte,
  input  logic              word_valid,
  output logic              word_ready,
  input  logic [WORD_W-1:0] word_data,
  output logic              res_valid,
  output logic              res_fail,
  output logic              res_erased,
  output logic [CNT_W-1:0]  res_count
);

  localparam int WORD_BYTES  = WORD_W / 8;
  localparam int DATA_WORDS  = DATA_BYTES / WORD_BYTES;
  localparam int SPARE_WORDS = SPARE_BYTES / WORD_BYTES;
  localparam int ZW          = $clog2(WORD_W + 1);

  ecc_stat_t        st;
  logic             stat_fire, scan_start;
  logic             word_fire, last_word, area_switch;
  logic [ZW-1:0]    zeros;
  logic [CNT_W-1:0] total, total_next;
  logic             stopped, over_next;

  assign st         = decode_status(stat_byte);
  assign stat_fire  = stat_valid && stat_ready;
  assign scan_start = stat_fire && st.uncorrectable;

  epc_scan_ctrl #(
    .DATA_WORDS  (DATA_WORDS),
    .SPARE_WORDS (SPARE_WORDS)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (scan_start),
    .word_valid   (word_valid),
    .status_ready (stat_ready),
    .word_ready   (word_ready),
    .word_fire    (word_fire),
    .last_word    (last_word),
    .area_switch  (area_switch)
  );

  epc_zero_count #(
    .WORD_W (WORD_W),
    .LANE_W (8),
    .ZW     (ZW)
  ) u_zc (
    .word  (word_data),
    .zeros (zeros)
  );

  epc_flip_accum #(
    .CNT_W  (CNT_W),
    .ZW     (ZW),
    .THRESH (THRESH)
  ) u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (scan_start),
    .add_en     (word_fire),
    .zeros      (zeros),
    .total      (total),
    .stopped    (stopped),
    .total_next (total_next),
    .over_next  (over_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_fail   <= 1'b0;
      res_erased <= 1'b0;
      res_count  <= '0;
    end else if (stat_fire) begin
      res_fail   <= 1'b0;
      res_erased <= 1'b0;
      if (st.uncorrectable) begin
        res_valid <= 1'b0;
        res_count <= '0;
      end else begin
        res_valid <= 1'b1;
        res_count <= CNT_W'(st.corrected);
      end
    end else if (last_word) begin
      res_valid  <= 1'b1;
      res_fail   <= over_next;
      res_erased <= !over_next;
      res_count  <= total_next;
    end
  end

  // R1
  plain_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_fire && !stat_byte[7] |=> res_valid && !res_fail && !res_erased &&
      (res_count == CNT_W'($past(stat_byte[5:0]))));

  // R2
  scan_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_fire && stat_byte[7] |=> word_ready && !stat_ready && !res_valid);

  // R3
  area_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    area_switch |=> word_ready && !res_valid);

  // R6
  fail_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fail |-> (res_count > CNT_W'(THRESH)) && !res_erased);

  // R7
  erased_under_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_erased |-> (res_count <= CNT_W'(THRESH)) && !res_fail);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !stat_fire |=> res_valid && $stable(res_count) &&
      $stable(res_fail) && $stable(res_erased));

  // R5
  stop_reported_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_word && stopped |=> res_fail && (res_count == $past(total)));

endmodule

// File: tb/erased_page_checker_tb_top.sv
`timescale 1ns/1ps
module erased_page_checker_tb_top;

  localparam int STRENGTH = 8;
  localparam int DBYTES   = 64;
  localparam int SBYTES   = 16;
  localparam int WW       = 32;
  localparam int THR      = STRENGTH / 2;
  localparam int DW       = DBYTES / 4;
  localparam int SW       = SBYTES / 4;
  localparam int NW       = DW + SW;
  localparam int CW       = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          stat_valid = 1'b0;
  logic [7:0]    stat_byte = '0;
  logic          word_valid = 1'b0;
  logic [WW-1:0] word_data = '0;
  logic          stat_ready, word_ready, res_valid, res_fail, res_erased;
  logic [CW-1:0] res_count;

  always #4 clk = ~clk;

  erased_page_checker #(
    .ECC_STRENGTH (STRENGTH),
    .DATA_BYTES   (DBYTES),
    .SPARE_BYTES  (SBYTES),
    .WORD_W       (WW)
  ) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .stat_valid (stat_valid),
    .stat_ready (stat_ready),
    .stat_byte  (stat_byte),
    .word_valid (word_valid),
    .word_ready (word_ready),
    .word_data  (word_data),
    .res_valid  (res_valid),
    .res_fail   (res_fail),
    .res_erased (res_erased),
    .res_count  (res_count)
  );

  int n_checks = 0;
  int n_errors = 0;

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  bit m_busy, m_stop, m_valid, m_fail, m_erased;
  int m_total, m_idx, m_count;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_stop = 0; m_valid = 0; m_fail = 0; m_erased = 0;
      m_total = 0; m_idx = 0; m_count = 0;
    end else if (!m_busy && stat_valid) begin
      m_fail = 0; m_erased = 0;
      if (stat_byte[7]) begin
        m_busy = 1; m_stop = 0; m_total = 0; m_idx = 0;
        m_valid = 0; m_count = 0;
      end else begin
        m_valid = 1; m_count = int'(stat_byte & 8'h3F);
      end
    end else if (m_busy && word_valid) begin
      if (!m_stop) begin
        m_total += $countones(~word_data);
        if (m_total > THR) m_stop = 1;
      end
      m_idx++;
      if (m_idx == NW) begin
        m_busy = 0; m_valid = 1;
        m_fail = (m_total > THR); m_erased = !m_fail; m_count = m_total;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check_eq("R2", "stat_ready", int'(stat_ready), int'(!m_busy));
      check_eq("R10", "word_ready", int'(word_ready), int'(m_busy));
      check_eq("R8", "res_valid", int'(res_valid), int'(m_valid));
      check_eq("R6", "res_fail", int'(res_fail), int'(m_fail));
      check_eq("R7", "res_erased", int'(res_erased), int'(m_erased));
      check_eq("R3", "res_count", int'(res_count), m_count);
    end
  end

  logic [WW-1:0] page [NW];

  task automatic fill_ones();
    for (int i = 0; i < NW; i++) page[i] = '1;
  endtask

  task automatic send_status(input logic [7:0] b);
    stat_valid = 1'b1;
    stat_byte  = b;
    @(negedge clk);
    stat_valid = 1'b0;
  endtask

  task automatic send_page(input int gap);
    for (int i = 0; i < NW; i++) begin
      word_valid = 1'b1;
      word_data  = page[i];
      @(negedge clk);
      word_valid = 1'b0;
      if (gap > 0 && (i % 3) == 1) repeat (gap) @(negedge clk);
    end
  endtask

  task automatic scan_expect(input string req, input int gap, input int exp_fail, input int exp_cnt);
    send_status(8'h80);
    send_page(gap);
    check_eq(req, "valid", int'(res_valid), 1);
    check_eq(req, "fail", int'(res_fail), exp_fail);
    check_eq(req, "erased", int'(res_erased), 1 - exp_fail);
    check_eq(req, "count", int'(res_count), exp_cnt);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check_eq("R9", "stat_ready", int'(stat_ready), 1);
    check_eq("R9", "word_ready", int'(word_ready), 0);
    check_eq("R9", "res_valid", int'(res_valid), 0);
    check_eq("R9", "res_count", int'(res_count), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 plain corrected count, no scan
    send_status(8'h05);
    check_eq("R1", "valid", int'(res_valid), 1);
    check_eq("R1", "count", int'(res_count), 5);
    check_eq("R1", "word_ready", int'(word_ready), 0);
    // R1 bit 6 ignored
    send_status(8'h7F);
    check_eq("R1", "count bit6", int'(res_count), 63);
    check_eq("R1", "fail", int'(res_fail), 0);

    // R10 words offered while idle are not taken; R8 result holds
    word_valid = 1'b1;
    word_data  = '0;
    repeat (4) @(negedge clk);
    word_valid = 1'b0;
    check_eq("R10", "word_ready idle", int'(word_ready), 0);
    check_eq("R8", "held count", int'(res_count), 63);

    // R7 all ones: erased, zero flips
    fill_ones();
    scan_expect("R7", 0, 0, 0);

    // R4 exactly threshold, zeros in both areas
    fill_ones();
    page[0]      = 32'hFFFF_FFFE;
    page[DW-1]   = 32'h7FFF_FFFF;
    page[DW+SW-1] = 32'hFFFF_FFFC;
    scan_expect("R4", 0, 0, 4);
    // R3 same page with gaps in word_valid
    scan_expect("R3", 2, 0, 4);

    // R6 one flip above threshold
    page[DW+1] = 32'hEFFF_FFFF;
    scan_expect("R6", 0, 1, 5);

    // R5 early stop in data area, later zeros not counted
    fill_ones();
    page[2]  = 32'h0000_0000;
    page[5]  = 32'h0000_0000;
    page[DW] = 32'h0000_0000;
    scan_expect("R5", 1, 1, 32);

    // R5 crossing inside spare area
    fill_ones();
    page[0]    = 32'hFFFF_FFF8;
    page[DW]   = 32'hFFFF_0FFF;
    page[DW+1] = 32'h0000_0000;
    scan_expect("R5", 0, 1, 7);

    // R8 result held over idle cycles, dropped by new scan start
    repeat (5) @(negedge clk);
    check_eq("R8", "hold valid", int'(res_valid), 1);
    check_eq("R8", "hold count", int'(res_count), 7);
    send_status(8'h80);
    check_eq("R8", "drop valid", int'(res_valid), 0);
    check_eq("R2", "busy stat_ready", int'(stat_ready), 0);
    // R2 status ignored while scanning
    stat_valid = 1'b1;
    stat_byte  = 8'h03;
    @(negedge clk);
    stat_valid = 1'b0;
    check_eq("R2", "still scanning", int'(word_ready), 1);
    fill_ones();
    send_page(0);
    check_eq("R2", "page length", int'(res_valid), 1);
    check_eq("R7", "count", int'(res_count), 0);

    // R1 after a scan
    send_status(8'h00);
    check_eq("R1", "zero count", int'(res_count), 0);
    check_eq("R1", "not erased", int'(res_erased), 0);

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule